// File: doc/BRIEF.md
# XGMII to Internal GMII Word Encoder

This block sits on the transmit side of a 2.5 Gb/s PCS that reuses a byte-wide 8b/10b coding path behind a 32-bit XGMII. Every clock it takes one XGMII column (four octets, four control flags) and produces four internal GMII byte codes. Each code is an enable bit, an error bit and an octet. A downstream serializer, which is not part of this block, sends the four codes out one at a time, lane 0 first.

Most columns map one to one: data, idle, low-power idle, start, terminate and error. Sequence and signal ordered sets are different. A four-octet ordered set becomes eight internal bytes. The sequence code is interleaved with four packed payload bytes S0..S3, and bit 7 of those bytes tells the set types apart. The expansion needs two output words. To make room, the encoder drops the ordered-set column that arrives right after one it has expanded, and sends the stored second half in its slot. A column that fits no rule becomes four error codes. All outputs are registered, with one cycle of latency.

Top module: `xgmii_gmii_word_enc`

## Requirements
- R1: A synchronous active-high reset sets all four output codes to idle (enable 0, error 0, octet 0x00) and clears the pending-half state. The first ordered-set column after reset therefore yields a first half.
- R2: A column with all four control flags clear yields four data codes (enable 1, error 0) carrying the column's octets in lane order, one clock after the column is presented.
- R3: A column of control 0x07 in every lane yields four idle codes. A column of control 0x06 in every lane yields four low-power idle codes (enable 0, error 1, octet 0x01).
- R4: A column with control 0xFB in lane 0 and data in lanes 1..3 yields the data code 0x55 in lane 0, followed by the data of lanes 1..3.
- R5: A column with control 0xFD in lane k, data in lanes below k and control 0x07 in lanes above k yields data codes below k and idle codes from lane k upward.
- R6: Control 0xFE in a lane that would otherwise carry data (all-data, start or terminate columns) yields a transmit error code (enable 1, error 1, octet 0x00) in that lane.
- R7: An ordered-set column (control 0x9C for a sequence set or 0x5C for a signal set in lane 0, octets X,Y,Z as data in lanes 1..3) with no half pending yields Seq,S0,Seq,S1 and marks a half pending. The Seq code is enable 0, error 1, octet 0x9C, and S bytes are data codes.
- R8: An ordered-set column arriving while a half is pending is discarded. It yields Seq,S2,Seq,S3 of the earlier set and clears the pending state.
- R9: Bit 7 of S0..S3 is 0,1,1,1 for a sequence set and 1,0,0,0 for a signal set.
- R10: S0[5:0]=X[5:0], S1[5:0]={Y[3:0],X[7:6]}, S2[5:0]={Z[1:0],Y[7:4]}, S3[5:0]=Z[7:2]. Bit 6 of each S byte equals its bit 5 when bit 2 is 1, and its bit 7 otherwise.
- R11: If the column after a first half is not an ordered set, the pending half is abandoned. That column is encoded by its own rule, and the next ordered-set column starts a new first half.
- R12: Any column matching none of the above yields four error codes (enable 1, error 1, octet 0x00).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| col_d | input | 32 | XGMII column octets, lane 0 in bits 7:0 |
| col_c | input | 4 | XGMII control flags, bit i for lane i |
| gm_en | output | 4 | Enable bit of each output code, bit i for lane i |
| gm_er | output | 4 | Error bit of each output code |
| gm_d | output | 32 | Octet of each output code, lane 0 in bits 7:0 |

## Verification
The ordered-set path gets a sweep of 256 payload triples, alternating between sequence and signal type. Each triple is followed by a second ordered-set column with a different payload. This shows whether the stored S2/S3 come from the first column or leak from the discarded one, and whether the bit-7 pattern follows the type. Terminate and error columns are driven for every lane position, which exposes off-by-one lane masks. The truncation runs and the back-to-back runs of three ordered-set columns separate the pending flag clearing correctly from clearing late or not at all. Malformed columns (mixed idle and LPI, misplaced start or ordered set, data after terminate) must fall to the error rule rather than a nearby one.

// File: rtl/xgenc_pkg.sv
package xgenc_pkg;
  localparam int unsigned OCT_W = 8;

  typedef struct packed {
    logic             en;
    logic             er;
    logic [OCT_W-1:0] d;
  } gcode_t;

  localparam logic [OCT_W-1:0] XC_IDLE  = 8'h07;
  localparam logic [OCT_W-1:0] XC_LPI   = 8'h06;
  localparam logic [OCT_W-1:0] XC_START = 8'hFB;
  localparam logic [OCT_W-1:0] XC_TERM  = 8'hFD;
  localparam logic [OCT_W-1:0] XC_ERR   = 8'hFE;
  localparam logic [OCT_W-1:0] XC_SEQ   = 8'h9C;
  localparam logic [OCT_W-1:0] XC_SIG   = 8'h5C;

  localparam logic [OCT_W-1:0] G_LPI_D = 8'h01;
  localparam logic [OCT_W-1:0] G_SEQ_D = 8'h9C;
  localparam logic [OCT_W-1:0] G_PRE_D = 8'h55;

  function automatic gcode_t g_idle();
    gcode_t r;
    r.en = 1'b0; r.er = 1'b0; r.d = '0;
    return r;
  endfunction

  function automatic gcode_t g_lpi();
    gcode_t r;
    r.en = 1'b0; r.er = 1'b1; r.d = G_LPI_D;
    return r;
  endfunction

  function automatic gcode_t g_seq();
    gcode_t r;
    r.en = 1'b0; r.er = 1'b1; r.d = G_SEQ_D;
    return r;
  endfunction

  function automatic gcode_t g_err();
    gcode_t r;
    r.en = 1'b1; r.er = 1'b1; r.d = '0;
    return r;
  endfunction

  function automatic gcode_t g_data(input logic [OCT_W-1:0] b);
    gcode_t r;
    r.en = 1'b1; r.er = 1'b0; r.d = b;
    return r;
  endfunction
endpackage

// File: rtl/xgenc_colmap.sv
module xgenc_colmap
  import xgenc_pkg::*;
#(
  parameter int unsigned LANES = 4,
  localparam int unsigned COL_W = LANES * OCT_W
) (
  input  logic [COL_W-1:0]       col_d,
  input  logic [LANES-1:0]       col_c,
  output gcode_t [LANES-1:0]     norm,
  output logic                   is_ordset,
  output logic                   is_sig
);
  logic [LANES-1:0] l_dat, l_err, l_dok, l_idle, l_lpi, l_term;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [OCT_W-1:0] b;
    assign b         = col_d[i*OCT_W +: OCT_W];
    assign l_dat[i]  = !col_c[i];
    assign l_err[i]  = col_c[i] && (b == XC_ERR);
    assign l_dok[i]  = l_dat[i] || l_err[i];
    assign l_idle[i] = col_c[i] && (b == XC_IDLE);
    assign l_lpi[i]  = col_c[i] && (b == XC_LPI);
    assign l_term[i] = col_c[i] && (b == XC_TERM);
  end

  logic [OCT_W-1:0] b0;
  assign b0 = col_d[OCT_W-1:0];

  logic start_ok;
  assign start_ok  = col_c[0] && (b0 == XC_START) && (&l_dok[LANES-1:1]);
  assign is_ordset = col_c[0] && ((b0 == XC_SEQ) || (b0 == XC_SIG)) && !(|col_c[LANES-1:1]);
  assign is_sig    = (b0 == XC_SIG);

  logic term_ok;
  logic [LANES-1:0] term_low;

  always_comb begin
    logic found;
    found    = 1'b0;
    term_ok  = 1'b0;
    term_low = '0;
    for (int k = 0; k < LANES; k++) begin
      if (!found && l_term[k]) begin
        found   = 1'b1;
        term_ok = 1'b1;
        for (int j = 0; j < LANES; j++) begin
          if (j < k) begin
            term_low[j] = 1'b1;
            if (!l_dok[j]) term_ok = 1'b0;
          end else if (j > k) begin
            if (!l_idle[j]) term_ok = 1'b0;
          end
        end
      end
    end
  end

  function automatic gcode_t dmap(input logic e, input logic [OCT_W-1:0] b);
    return e ? g_err() : g_data(b);
  endfunction

  always_comb begin
    for (int i = 0; i < LANES; i++) norm[i] = g_err();
    if (&l_dok) begin
      for (int i = 0; i < LANES; i++) norm[i] = dmap(l_err[i], col_d[i*OCT_W +: OCT_W]);
    end else if (&l_idle) begin
      for (int i = 0; i < LANES; i++) norm[i] = g_idle();
    end else if (&l_lpi) begin
      for (int i = 0; i < LANES; i++) norm[i] = g_lpi();
    end else if (start_ok) begin
      norm[0] = g_data(G_PRE_D);
      for (int i = 1; i < LANES; i++) norm[i] = dmap(l_err[i], col_d[i*OCT_W +: OCT_W]);
    end else if (term_ok) begin
      for (int i = 0; i < LANES; i++)
        norm[i] = term_low[i] ? dmap(l_err[i], col_d[i*OCT_W +: OCT_W]) : g_idle();
    end
  end
endmodule

// File: rtl/xgenc_seqpack.sv
module xgenc_seqpack
  import xgenc_pkg::*;
#(
  parameter int unsigned SETS = 4
) (
  input  logic [OCT_W-1:0]            x,
  input  logic [OCT_W-1:0]            y,
  input  logic [OCT_W-1:0]            z,
  input  logic                        sig,
  output logic [SETS-1:0][OCT_W-1:0]  s
);
  logic [SETS-1:0][5:0] six;
  assign six[0] = x[5:0];
  assign six[1] = {y[3:0], x[7:6]};
  assign six[2] = {z[1:0], y[7:4]};
  assign six[3] = z[7:2];

  for (genvar n = 0; n < SETS; n++) begin : g_byte
    logic top;
    assign top  = (n == 0) ? sig : !sig;
    assign s[n] = {top, (six[n][2] ? six[n][5] : top), six[n]};
  end

  always_comb begin
    for (int n = 0; n < SETS; n++)
      assert_bit6_R10: assert (s[n][6] == (s[n][2] ? s[n][5] : s[n][7]));
  end
endmodule

// File: rtl/xgmii_gmii_word_enc.sv
module xgmii_gmii_word_enc
  import xgenc_pkg::*;
#(
  parameter int unsigned LANES = 4,
  localparam int unsigned COL_W = LANES * OCT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [COL_W-1:0] col_d,
  input  logic [LANES-1:0] col_c,
  output logic [LANES-1:0] gm_en,
  output logic [LANES-1:0] gm_er,
  output logic [COL_W-1:0] gm_d
);
  gcode_t [LANES-1:0] norm, code_n, code_q;
  logic is_ordset, is_sig;

  xgenc_colmap #(.LANES(LANES)) u_map (
    .col_d(col_d), .col_c(col_c), .norm(norm),
    .is_ordset(is_ordset), .is_sig(is_sig)
  );

  logic [3:0][OCT_W-1:0] sb;
  xgenc_seqpack #(.SETS(4)) u_pack (
    .x(col_d[15:8]), .y(col_d[23:16]), .z(col_d[31:24]),
    .sig(is_sig), .s(sb)
  );

  logic pend_q, pend_n;
  logic [1:0][OCT_W-1:0] hold_q, hold_n;

  always_comb begin
    code_n = norm;
    pend_n = 1'b0;
    hold_n = hold_q;
    if (pend_q) begin
      if (is_ordset) begin
        code_n[0] = g_seq();
        code_n[1] = g_data(hold_q[0]);
        code_n[2] = g_seq();
        code_n[3] = g_data(hold_q[1]);
      end
    end else if (is_ordset) begin
      code_n[0] = g_seq();
      code_n[1] = g_data(sb[0]);
      code_n[2] = g_seq();
      code_n[3] = g_data(sb[1]);
      pend_n    = 1'b1;
      hold_n    = {sb[3], sb[2]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LANES; i++) code_q[i] <= g_idle();
      pend_q <= 1'b0;
      hold_q <= '0;
    end else begin
      code_q <= code_n;
      pend_q <= pend_n;
      hold_q <= hold_n;
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_out
    assign gm_en[i]                 = code_q[i].en;
    assign gm_er[i]                 = code_q[i].er;
    assign gm_d[i*OCT_W +: OCT_W]   = code_q[i].d;

    assert_ctrl_code_R3: assert property (@(posedge clk) disable iff (rst)
      (!gm_en[i] && gm_er[i]) |-> (gm_d[i*OCT_W +: OCT_W] == G_LPI_D ||
                                   gm_d[i*OCT_W +: OCT_W] == G_SEQ_D));
  end

  assert_half_once_R8: assert property (@(posedge clk) disable iff (rst)
    pend_q |=> !pend_q);

  assert_first_half_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(pend_q) |-> (!gm_en[0] && gm_er[0] && gm_d[7:0] == G_SEQ_D && gm_en[1]));

  assert_seq_pair_R7: assert property (@(posedge clk) disable iff (rst)
    (!gm_en[0] && gm_er[0] && gm_d[7:0] == G_SEQ_D) |->
      (!gm_en[2] && gm_er[2] && gm_d[23:16] == G_SEQ_D && gm_en[1] && gm_en[3]));

  assert_bit7_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(pend_q) |-> (gm_d[15] != gm_d[31]));
endmodule

// File: tb/xgmii_gmii_word_enc_test.sv
module xgmii_gmii_word_enc_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [31:0] col_d = 32'h07070707;
  logic [3:0]  col_c = 4'hF;
  logic [3:0]  gm_en, gm_er;
  logic [31:0] gm_d;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  xgmii_gmii_word_enc uut (
    .clk(clk), .rst(rst), .col_d(col_d), .col_c(col_c),
    .gm_en(gm_en), .gm_er(gm_er), .gm_d(gm_d)
  );

  task automatic chk(input logic [3:0] en, input logic [3:0] er,
                     input logic [31:0] d, input string req);
    checks++;
    if (gm_en !== en || gm_er !== er || gm_d !== d) begin
      errors++;
      $display("FAIL %s: got en=%b er=%b d=%h, expected en=%b er=%b d=%h",
               req, gm_en, gm_er, gm_d, en, er, d);
    end
  endtask

  // drive a column at a falling edge, check at the next falling edge
  task automatic col(input logic [31:0] d, input logic [3:0] c,
                     input logic [3:0] en, input logic [3:0] er,
                     input logic [31:0] ed, input string req);
    col_d = d; col_c = c;
    @(negedge clk);
    chk(en, er, ed, req);
  endtask

  function automatic logic [7:0] sbyte(input int n, input logic [7:0] x,
                                       input logic [7:0] y, input logic [7:0] z,
                                       input bit sig);
    logic [23:0] p;
    logic [5:0]  six;
    logic        b7, b6;
    p   = {z, y, x};
    six = p[6*n +: 6];
    b7  = sig ? (n == 0) : (n != 0);
    b6  = six[2] ? six[5] : b7;
    return {b7, b6, six};
  endfunction

  function automatic logic [31:0] half(input bit second, input logic [7:0] x,
                                       input logic [7:0] y, input logic [7:0] z,
                                       input bit sig);
    int a;
    a = second ? 2 : 0;
    return {sbyte(a + 1, x, y, z, sig), 8'h9C, sbyte(a, x, y, z, sig), 8'h9C};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(4'h0, 4'h0, 32'h0, "R1 reset idle");
    // R1: pending state clear -> first half
    col(32'h332211_9C, 4'b0001, 4'b1010, 4'b0101,
        half(0, 8'h11, 8'h22, 8'h33, 0), "R1 first after reset");
    col(32'h07070707, 4'hF, 4'h0, 4'h0, 32'h0, "R11 idle truncates");

    // R2 all-data
    for (int i = 0; i < 24; i++) begin
      logic [31:0] v;
      v = 32'h9E3779B9 * (i + 1) + 32'h1234;
      col(v, 4'h0, 4'hF, 4'h0, v, "R2 data");
    end

    // R3 idle and LPI
    col(32'h07070707, 4'hF, 4'h0, 4'h0, 32'h0, "R3 idle");
    col(32'h06060606, 4'hF, 4'h0, 4'hF, 32'h01010101, "R3 lpi");

    // R4 start
    for (int i = 0; i < 8; i++) begin
      logic [23:0] v;
      v = 24'hA5C3F1 ^ (24'h010203 * i);
      col({v, 8'hFB}, 4'b0001, 4'hF, 4'h0, {v, 8'h55}, "R4 start");
    end

    // R5 terminate in each lane
    for (int k = 0; k < 4; k++) begin
      logic [31:0] d, ed;
      logic [3:0]  c, en;
      d = '0; ed = '0; c = '0; en = '0;
      for (int j = 0; j < 4; j++) begin
        if (j < k) begin
          d[8*j +: 8] = 8'h40 + 8'(j * 17 + k); ed[8*j +: 8] = d[8*j +: 8]; en[j] = 1'b1;
        end else if (j == k) begin
          d[8*j +: 8] = 8'hFD; c[j] = 1'b1;
        end else begin
          d[8*j +: 8] = 8'h07; c[j] = 1'b1;
        end
      end
      col(d, c, en, 4'h0, ed, "R5 terminate");
    end

    // R6 error lanes in data, start and terminate columns
    for (int j = 0; j < 4; j++) begin
      logic [31:0] d, ed;
      d = 32'h8C6B4A29; d[8*j +: 8] = 8'hFE;
      ed = d; ed[8*j +: 8] = 8'h00;
      col(d, 4'(1 << j), 4'hF, 4'(1 << j), ed, "R6 error in data");
    end
    col(32'h33FE11FB, 4'b0101, 4'hF, 4'b0100, 32'h33001155, "R6 error in start");
    col(32'h07FDFE5A, 4'b1110, 4'b0011, 4'b0010, 32'h0000005A, "R6 error before terminate");

    // R7..R10 sweep of ordered-set pairs
    for (int i = 0; i < 256; i++) begin
      logic [7:0] x, y, z;
      bit sig;
      x = 8'(i); y = 8'(i * 37 + 5); z = 8'(i * 101 + 3); sig = i[0];
      col({z, y, x, (sig ? 8'h5C : 8'h9C)}, 4'b0001, 4'b1010, 4'b0101,
          half(0, x, y, z, sig), "R7 R9 R10 first half");
      col({~z, ~y, ~x, 8'h9C}, 4'b0001, 4'b1010, 4'b0101,
          half(1, x, y, z, sig), "R8 R9 R10 second half");
    end

    // R8: three in a row -> third starts fresh
    col(32'hC0FFEE_5C, 4'b0001, 4'b1010, 4'b0101, half(0, 8'hEE, 8'hFF, 8'hC0, 1), "R8 run a");
    col(32'h123456_9C, 4'b0001, 4'b1010, 4'b0101, half(1, 8'hEE, 8'hFF, 8'hC0, 1), "R8 run b");
    col(32'hABCDEF_9C, 4'b0001, 4'b1010, 4'b0101, half(0, 8'hEF, 8'hCD, 8'hAB, 0), "R8 run c");
    col(32'h000000_9C, 4'b0001, 4'b1010, 4'b0101, half(1, 8'hEF, 8'hCD, 8'hAB, 0), "R8 run d");

    // R11 truncation by data and by LPI, then fresh first half
    col(32'h445566_9C, 4'b0001, 4'b1010, 4'b0101, half(0, 8'h66, 8'h55, 8'h44, 0), "R11 set");
    col(32'hDEADBEEF, 4'h0, 4'hF, 4'h0, 32'hDEADBEEF, "R11 data truncates");
    col(32'h778899_5C, 4'b0001, 4'b1010, 4'b0101, half(0, 8'h99, 8'h88, 8'h77, 1), "R11 fresh");
    col(32'h06060606, 4'hF, 4'h0, 4'hF, 32'h01010101, "R11 lpi truncates");
    col(32'h010203_9C, 4'b0001, 4'b1010, 4'b0101, half(0, 8'h03, 8'h02, 8'h01, 0), "R11 fresh 2");
    col(32'h07070707, 4'hF, 4'h0, 4'h0, 32'h0, "R11 idle");

    // R12 unmatched columns
    col(32'h07060707, 4'hF, 4'hF, 4'hF, 32'h0, "R12 idle/lpi mix");
    col(32'h2211FB00, 4'b0010, 4'hF, 4'hF, 32'h0, "R12 start lane1");
    col(32'h229C1100, 4'b0100, 4'hF, 4'hF, 32'h0, "R12 ordset lane2");
    col(32'h55FD1100, 4'b0100, 4'hF, 4'hF, 32'h0, "R12 data after terminate");
    col(32'h07070707, 4'hF, 4'h0, 4'h0, 32'h0, "R12 recover idle");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule